// File: doc/BRIEF.md
# Register-Pair Unsigned Divider

This block divides a 32-bit unsigned value by a 16-bit unsigned divisor over several clock cycles. The dividend is held in two 16-bit registers inside the block. The high word (Y) sits above the low word (A). When a division finishes, the quotient, rounded down, replaces the low word and the remainder replaces the high word. Both words can be loaded through write ports whenever the unit is idle. They are visible on the outputs at all times.

A division starts with a one-cycle start pulse, and the divisor is captured on that cycle. The unit runs restoring radix-2 division, one quotient bit per cycle, and then writes the results back in one extra cycle. If the divisor is zero, the unit sets an error flag and a break flag, which a surrounding core uses to halt execution, and leaves both words as they were. The division leaves the arithmetic condition flags of the surrounding core untouched, so no such flags exist here. Because the remainder lands in the high word, a second division without reloading uses that remainder as its upper dividend half.

Top module: `pairdiv_core`

## Requirements
- R1: After synchronous reset, busy, done, err_flag and brk_flag are 0 and hi_word and lo_word are 0.
- R2: When the unit is idle and start is low, wr_hi_en loads wr_hi_data into hi_word and wr_lo_en loads wr_lo_data into lo_word. The new value is visible on the cycle after the write.
- R3: For a nonzero divisor d, let D = hi_word*65536 + lo_word at start. When the division completes, lo_word equals bits 15:0 of floor(D/d) and hi_word equals D mod d.
- R4: An accepted start with a nonzero divisor raises busy on the next cycle. busy stays high for exactly 33 cycles. On the first cycle after that, busy is 0, done is 1 for that one cycle, and the results are already on hi_word and lo_word.
- R5: A start with divisor 0 while idle gives done=1, err_flag=1 and brk_flag=1 on the next cycle. busy stays 0, and hi_word and lo_word keep their values.
- R6: err_flag and brk_flag stay at 1 once set, including across later divisions, until synchronous reset clears them.
- R7: While busy is high, start is ignored, and changes to divisor have no effect on the division in progress.
- R8: A second division started without reloading the words uses the previous remainder as the high dividend word and the previous quotient low half as the low word.
- R9: When floor(D/d) exceeds 16 bits, lo_word receives only its low 16 bits and hi_word still receives the exact remainder.
- R10: Writes are ignored while busy is high, and a write issued in the same cycle as a start that the unit accepts is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_hi_en | input | 1 | Write enable for the high word |
| wr_hi_data | input | 16 | Data for the high word |
| wr_lo_en | input | 1 | Write enable for the low word |
| wr_lo_data | input | 16 | Data for the low word |
| start | input | 1 | Begin a division (one-cycle pulse) |
| divisor | input | 16 | Divisor, captured with start |
| hi_word | output | 16 | High word (Y); holds the remainder after a division |
| lo_word | output | 16 | Low word (A); holds the quotient low half after a division |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sticky divide-by-zero error |
| brk_flag | output | 1 | Sticky halt request raised on divide-by-zero |

## Verification
The assertions check on every cycle that:
- busy lasts exactly 33 cycles;
- done never coincides with busy;
- both words hold steady throughout a division;
- a zero-divisor start produces done, error and break on the next cycle without touching the words;
- the error flag is sticky.

Only the bench scenarios can show the arithmetic itself. These scenarios cover the quotient and remainder values, quotient truncation, remainder chaining between back-to-back divisions, and that stray writes, starts and divisor changes during a division leave the result unaffected.

// File: rtl/pairdiv_pkg.sv
package pairdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2
  } div_state_e;
endpackage

// File: rtl/pairdiv_step.sv
// One restoring radix-2 step: shift in the next dividend bit, trial-subtract.
module pairdiv_step #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]   rem_in,
  input  logic [2*WORD_W-1:0] dq_in,
  input  logic [WORD_W-1:0]   dsr,
  output logic [WORD_W-1:0]   rem_out,
  output logic [2*WORD_W-1:0] dq_out
);
  localparam int DW = 2 * WORD_W;

  logic [WORD_W:0]   shifted;
  logic [WORD_W+1:0] trial;
  logic              take;

  always_comb begin
    shifted = {rem_in, dq_in[DW-1]};
    trial   = {1'b0, shifted} - {2'b00, dsr};
    take    = ~trial[WORD_W+1];
    rem_out = take ? trial[WORD_W-1:0] : shifted[WORD_W-1:0];
    dq_out  = {dq_in[DW-2:0], take};
  end
endmodule

// File: rtl/pairdiv_ctrl.sv
// Sequencer: idle -> run (one step per cycle) -> write-back.
module pairdiv_ctrl
  import pairdiv_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dsr_zero,
  output logic load,
  output logic step,
  output logic wb,
  output logic busy,
  output logic done,
  output logic err,
  output logic brk
);
  localparam int DIV_STEPS = 2 * WORD_W;
  localparam int CNT_W     = $clog2(DIV_STEPS);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIV_STEPS - 1);

  div_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  assign load = (st_q == ST_IDLE) && start && !dsr_zero;
  assign step = (st_q == ST_RUN);
  assign wb   = (st_q == ST_WB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      brk   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (dsr_zero) begin
              done <= 1'b1;
              err  <= 1'b1;
              brk  <= 1'b1;
            end else begin
              st_q  <= ST_RUN;
              cnt_q <= '0;
              busy  <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) st_q <= ST_WB;
        end
        ST_WB: begin
          st_q <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pairdiv_datapath.sv
// Partial remainder, shifting dividend/quotient and captured divisor.
module pairdiv_datapath #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [WORD_W-1:0] hi_in,
  input  logic [WORD_W-1:0] lo_in,
  input  logic [WORD_W-1:0] divisor,
  output logic [WORD_W-1:0] quo_lo,
  output logic [WORD_W-1:0] rem
);
  localparam int DW = 2 * WORD_W;

  logic [WORD_W-1:0] rem_q, rem_n, dsr_q;
  logic [DW-1:0]     dq_q, dq_n;

  pairdiv_step #(.WORD_W(WORD_W)) u_step (
    .rem_in (rem_q),
    .dq_in  (dq_q),
    .dsr    (dsr_q),
    .rem_out(rem_n),
    .dq_out (dq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dq_q  <= '0;
      dsr_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      dq_q  <= {hi_in, lo_in};
      dsr_q <= divisor;
    end else if (step) begin
      rem_q <= rem_n;
      dq_q  <= dq_n;
    end
  end

  assign quo_lo = dq_q[WORD_W-1:0];
  assign rem    = rem_q;
endmodule

// File: rtl/pairdiv_regpair.sv
// The Y:A register pair with host write ports and divider write-back.
module pairdiv_regpair #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_block,
  input  logic              wr_hi_en,
  input  logic [WORD_W-1:0] wr_hi_data,
  input  logic              wr_lo_en,
  input  logic [WORD_W-1:0] wr_lo_data,
  input  logic              wb,
  input  logic [WORD_W-1:0] wb_hi,
  input  logic [WORD_W-1:0] wb_lo,
  output logic [WORD_W-1:0] hi_q,
  output logic [WORD_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wb) begin
      hi_q <= wb_hi;
      lo_q <= wb_lo;
    end else if (!wr_block) begin
      if (wr_hi_en) hi_q <= wr_hi_data;
      if (wr_lo_en) lo_q <= wr_lo_data;
    end
  end
endmodule

// File: rtl/pairdiv_core.sv
module pairdiv_core #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi_en,
  input  logic [WORD_W-1:0] wr_hi_data,
  input  logic              wr_lo_en,
  input  logic [WORD_W-1:0] wr_lo_data,
  input  logic              start,
  input  logic [WORD_W-1:0] divisor,
  output logic [WORD_W-1:0] hi_word,
  output logic [WORD_W-1:0] lo_word,
  output logic              busy,
  output logic              done,
  output logic              err_flag,
  output logic              brk_flag
);
  logic              load, step, wb;
  logic [WORD_W-1:0] quo_lo, rem;

  pairdiv_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .dsr_zero(divisor == '0),
    .load    (load),
    .step    (step),
    .wb      (wb),
    .busy    (busy),
    .done    (done),
    .err     (err_flag),
    .brk     (brk_flag)
  );

  pairdiv_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .hi_in  (hi_word),
    .lo_in  (lo_word),
    .divisor(divisor),
    .quo_lo (quo_lo),
    .rem    (rem)
  );

  pairdiv_regpair #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_block  (busy | start),
    .wr_hi_en  (wr_hi_en),
    .wr_hi_data(wr_hi_data),
    .wr_lo_en  (wr_lo_en),
    .wr_lo_data(wr_lo_data),
    .wb        (wb),
    .wb_hi     (rem),
    .wb_lo     (quo_lo),
    .hi_q      (hi_word),
    .lo_q      (lo_word)
  );
endmodule

// File: rtl/pairdiv_core_chk.sv
module pairdiv_core_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] divisor,
  input logic [WORD_W-1:0] hi_word,
  input logic [WORD_W-1:0] lo_word,
  input logic              busy,
  input logic              done,
  input logic              err_flag,
  input logic              brk_flag
);
  localparam int BUSY_LEN = 2 * WORD_W + 1;
  localparam int BC_W     = $clog2(BUSY_LEN + 2);

  logic [BC_W-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R4: busy lasts exactly the step count plus write-back
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bcnt == BC_W'(BUSY_LEN));
  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> bcnt < BC_W'(BUSY_LEN));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4: an accepted nonzero start raises busy
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0) |=> busy);
  // R5: zero divisor
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=>
      (done && err_flag && brk_flag && !busy &&
       hi_word == $past(hi_word) && lo_word == $past(lo_word)));
  // R6: sticky flags
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  assert_brk_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    brk_flag |=> brk_flag);
  // R10: words hold while busy
  assert_words_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(hi_word) && $stable(lo_word)));
endmodule

bind pairdiv_core pairdiv_core_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .divisor (divisor),
  .hi_word (hi_word),
  .lo_word (lo_word),
  .busy    (busy),
  .done    (done),
  .err_flag(err_flag),
  .brk_flag(brk_flag)
);

// File: tb/pairdiv_core_tb.sv
module pairdiv_core_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst, start, wr_hi_en, wr_lo_en;
  logic [W-1:0] wr_hi_data, wr_lo_data, divisor;
  logic [W-1:0] hi_word, lo_word;
  logic         busy, done, err_flag, brk_flag;

  int n_checks = 0;
  int n_errs   = 0;
  logic [W-1:0] mdl_hi, mdl_lo;

  always #2 clk = ~clk;

  pairdiv_core #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst),
    .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
    .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
    .start(start), .divisor(divisor),
    .hi_word(hi_word), .lo_word(lo_word),
    .busy(busy), .done(done), .err_flag(err_flag), .brk_flag(brk_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_quo(input logic [W-1:0] y, input logic [W-1:0] a, input logic [W-1:0] d);
    logic [2*W-1:0] dvd;
    dvd = {y, a};
    return W'(dvd / {{W{1'b0}}, d});
  endfunction

  function automatic logic [W-1:0] exp_rem(input logic [W-1:0] y, input logic [W-1:0] a, input logic [W-1:0] d);
    logic [2*W-1:0] dvd;
    dvd = {y, a};
    return W'(dvd % {{W{1'b0}}, d});
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mdl_hi = '0;
    mdl_lo = '0;
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    chk(err_flag === 1'b0 && brk_flag === 1'b0, "R1 flags after reset", {err_flag, brk_flag}, 0);
    chk(hi_word === 0 && lo_word === 0, "R1 words after reset", {hi_word, lo_word}, 0);
  endtask

  task automatic load_pair(input logic [W-1:0] y, input logic [W-1:0] a);
    wr_hi_en = 1'b1; wr_hi_data = y;
    wr_lo_en = 1'b1; wr_lo_data = a;
    @(negedge clk);
    wr_hi_en = 1'b0; wr_lo_en = 1'b0;
    mdl_hi = y;
    mdl_lo = a;
    chk(hi_word === y && lo_word === a, "R2 load pair", {hi_word, lo_word}, {y, a});
  endtask

  // Called at a negedge with the unit idle. Leaves at a negedge, unit idle.
  task automatic run_div(input logic [W-1:0] d, input bit disturb, input string tag);
    bit seq_ok;
    logic [W-1:0] eq, er;
    start = 1'b1;
    divisor = d;
    @(negedge clk);
    start = 1'b0;
    wr_hi_en = 1'b0;
    wr_lo_en = 1'b0;
    if (d == 0) begin
      chk(done === 1'b1 && err_flag === 1'b1 && brk_flag === 1'b1 && busy === 1'b0,
          {tag, " R5 zero-divisor flags"}, {done, err_flag, brk_flag, busy}, 4'b1110);
      chk(hi_word === mdl_hi && lo_word === mdl_lo, {tag, " R5 words unchanged"},
          {hi_word, lo_word}, {mdl_hi, mdl_lo});
      return;
    end
    eq = exp_quo(mdl_hi, mdl_lo, d);
    er = exp_rem(mdl_hi, mdl_lo, d);
    seq_ok = 1'b1;
    for (int j = 1; j <= 2 * W + 1; j++) begin
      if (!(busy === 1'b1 && done === 1'b0)) seq_ok = 1'b0;
      if (disturb) begin
        start = 1'b1;
        divisor = W'($urandom);
        wr_hi_en = 1'b1; wr_hi_data = W'($urandom);
        wr_lo_en = 1'b1; wr_lo_data = W'($urandom);
      end
      @(negedge clk);
    end
    start = 1'b0;
    wr_hi_en = 1'b0;
    wr_lo_en = 1'b0;
    chk(seq_ok, {tag, " R4 busy held 33 cycles"}, seq_ok, 1);
    chk(busy === 1'b0 && done === 1'b1, {tag, " R4 done pulse"}, {busy, done}, 2'b01);
    chk(lo_word === eq, {tag, " R3 quotient"}, lo_word, eq);
    chk(hi_word === er, {tag, " R3 remainder"}, hi_word, er);
    mdl_hi = er;
    mdl_lo = eq;
    @(negedge clk);
    chk(done === 1'b0, {tag, " R4 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d17));
    start = 0; wr_hi_en = 0; wr_lo_en = 0;
    wr_hi_data = 0; wr_lo_data = 0; divisor = 0;
    do_reset();

    // R2: single-word write
    wr_hi_en = 1'b1; wr_hi_data = 16'h1234;
    @(negedge clk);
    wr_hi_en = 1'b0;
    mdl_hi = 16'h1234;
    chk(hi_word === 16'h1234 && lo_word === 16'h0000, "R2 high-only write", {hi_word, lo_word}, 32'h1234_0000);

    // R3 directed
    load_pair(16'h0000, 16'h0064);
    run_div(16'd7, 1'b0, "R3 100/7");
    chk(lo_word === 16'd14 && hi_word === 16'd2, "R3 100/7 literal", {hi_word, lo_word}, 32'h0002_000e);
    load_pair(16'h0001, 16'h0000);
    run_div(16'd2, 1'b0, "R3 65536/2");
    load_pair(16'h0000, 16'h0003);
    run_div(16'hFFFF, 1'b0, "R3 small/large");

    // R9 quotient wider than a word
    load_pair(16'hFFFF, 16'hFFFF);
    run_div(16'd1, 1'b0, "R9 max/1");
    chk(lo_word === 16'hFFFF && hi_word === 16'h0000, "R9 max/1 literal", {hi_word, lo_word}, 32'h0000_ffff);
    load_pair(16'h1234, 16'h5678);
    run_div(16'd3, 1'b0, "R9 trunc");

    // R8 chained divides reuse remainder
    load_pair(16'h0005, 16'h0000);
    run_div(16'd9, 1'b0, "R8 first");
    run_div(16'd7, 1'b0, "R8 chained");

    // R7/R10 disturbance while busy
    load_pair(16'h00AB, 16'hCDEF);
    run_div(16'h0123, 1'b1, "R7 R10 disturb");

    // R10 write in the same cycle as an accepted start
    wr_hi_en = 1'b1; wr_hi_data = 16'h7777;
    wr_lo_en = 1'b1; wr_lo_data = 16'h8888;
    run_div(16'd5, 1'b0, "R10 write with start");

    // random
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] d;
      if (($urandom % 4) != 0)
        load_pair(W'($urandom), W'($urandom));
      d = (($urandom % 2) != 0) ? W'($urandom % 16 + 1) : W'($urandom);
      if (d == 0) d = 16'd1;
      run_div(d, ($urandom % 5) == 0, "R3 random");
    end

    // R5/R6 zero divisor
    load_pair(16'h4321, 16'h8765);
    run_div(16'd0, 1'b0, "R5");
    @(negedge clk);
    chk(done === 1'b0 && err_flag === 1'b1 && brk_flag === 1'b1, "R6 flags stay after zero divide",
        {done, err_flag, brk_flag}, 3'b011);
    run_div(16'd10, 1'b0, "R6 divide after error");
    chk(err_flag === 1'b1 && brk_flag === 1'b1, "R6 flags survive division", {err_flag, brk_flag}, 2'b11);
    do_reset();
    chk(err_flag === 1'b0 && brk_flag === 1'b0, "R6 reset clears flags", {err_flag, brk_flag}, 0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule